// File: doc/BRIEF.md
# Lockstep PRBS Licence Checker

This block lives inside the device being protected. It checks a pseudo-random bit stream that comes from a small external security companion. Both the block and the companion hold an identical 36-bit XOR-feedback shift register loaded with the same fixed seed. The block produces the companion's clock by dividing the main system clock by a power of two. Because of this, both registers step on the same edges, and no separate clock exists that could be tied off to freeze the stream.

After reset the stream runs without pause and repeats the same sequence every time. Each incoming bit passes through a two-flop synchroniser and is then compared with the block's own prediction. A saturating mismatch score rises by one on each wrong bit and falls by one on each right bit. When the score reaches a programmable threshold, the block latches a fault and removes its enable output. The fault stays latched until the next reset.

A run control stops the companion clock and later resumes it. While the clock is stopped, the prediction, the comparison and the score all hold their values.

Top module: `prbs_lockstep_chk`

## Requirements
- R1: While reset is applied and right after it is released, `enable_o` is 1, `fault_o` is 0 and `comp_clk_o` is 0.
- R2: `comp_clk_o` has a period of 2^N system clocks with a 50% duty cycle. N is `div_log2_i`, and any value below 2 is treated as 2. The first rising edge comes on the 2^(N-1)-th clock edge after reset is released.
- R3: While `run_i` is 0, `comp_clk_o` keeps its level and the predictor, the score and the fault state hold. Once `run_i` returns to 1, a companion that stayed frozen remains in step and raises no fault.
- R4: The predictor is 36 bits wide with seed 36'hA5C31E9F7. Each step shifts the state left by one and inserts bit35 XOR bit24 at bit 0. The predicted bit is bit 35. The companion steps on each rising edge of `comp_clk_o` and drives its bit 35 on `prbs_bit_i`. A companion built this way never causes a fault.
- R5: The bits checked at the first two rising edges of `comp_clk_o` after reset are not compared. These are the bits the companion drove before its second rising edge.
- R6: The bit the companion drives after rising edge k is compared at rising edge k+1. A mismatch adds 1 to the score and a match subtracts 1, with a floor of 0. The score changes by at most one per step. When the score reaches `threshold_i`, `fault_o` rises and `enable_o` falls on the same clock edge on which `comp_clk_o` rises.
- R7: Once set, the fault stays set until reset, even when the stream becomes correct again.
- R8: A `threshold_i` of 0 disables the fault, whatever bits arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | 1 runs the companion clock and the check; 0 suspends both |
| div_log2_i | input | 4 | Divider exponent N (period 2^N, minimum 2) |
| threshold_i | input | 8 | Score at which the fault trips; 0 disables |
| prbs_bit_i | input | 1 | Bit stream from the companion |
| comp_clk_o | output | 1 | Divided clock for the companion |
| enable_o | output | 1 | Licence enable; 0 once a fault is latched |
| fault_o | output | 1 | Latched fault flag |

## Verification
The assertions check several properties on every cycle:
- the fault never clears once set;
- a fault can rise only on the same edge as the companion clock;
- the clock level and the score freeze whenever `run_i` is low;
- the score moves by at most one;
- the predictor never sits in the all-zero state;
- a zero threshold never lets a fault appear.

Some properties can only be shown by the bench scenarios, which run an independent companion model:
- the divided period and first-edge timing;
- the skipping of the first two compares;
- the exact step at which the score trips after a run of bad bits;
- whether alternating good and bad bits keep the score below the threshold;
- staying in lockstep across a suspend while the input is disturbed.

// File: rtl/prbs_lockstep_pkg.sv
`timescale 1ns/1ps
package prbs_lockstep_pkg;

  localparam int unsigned PRED_W = 36;
  localparam logic [PRED_W-1:0] PRED_TAPS = (PRED_W'(1) << 35) | (PRED_W'(1) << 24);
  localparam logic [PRED_W-1:0] PRED_SEED = 36'hA5C31E9F7;

  typedef enum logic [1:0] {
    CHK_WARMUP = 2'd0,
    CHK_ACTIVE = 2'd1,
    CHK_FAULT  = 2'd2
  } chk_state_e;

endpackage

// File: rtl/prbs_clk_div.sv
`timescale 1ns/1ps
module prbs_clk_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_log2_i,
  output logic             step_o,
  output logic             clk_o
);

  localparam int unsigned CW = (1 << DIV_W) - 1;
  localparam int unsigned SW = CW + 1;

  logic [CW-1:0]    cnt_q;
  logic [DIV_W-1:0] n_eff;
  logic [SW-1:0]    span;
  logic [CW-1:0]    full_mask, half_mask, phase;
  logic             fall;
  logic             clk_q;

  always_comb begin
    n_eff     = (div_log2_i < DIV_W'(2)) ? DIV_W'(2) : div_log2_i;
    span      = SW'(1) << n_eff;
    full_mask = span[CW-1:0] - CW'(1);
    half_mask = CW'(span >> 1) - CW'(1);
    phase     = cnt_q & full_mask;
    step_o    = run_i && (phase == half_mask);
    fall      = run_i && (phase == full_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (run_i) begin
      cnt_q <= cnt_q + CW'(1);
      if (step_o)    clk_q <= 1'b1;
      else if (fall) clk_q <= 1'b0;
    end
  end

  assign clk_o = clk_q;

endmodule

// File: rtl/prbs_pred_lfsr.sv
`timescale 1ns/1ps
module prbs_pred_lfsr #(
  parameter int unsigned     W    = 36,
  parameter logic [W-1:0]    TAPS = '1,
  parameter logic [W-1:0]    SEED = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  // a zero seed would lock the register; substitute one
  localparam logic [W-1:0] SEED_OK = (SEED == '0) ? W'(1) : SEED;

  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED_OK;
    else if (step_i) state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;

endmodule

// File: rtl/prbs_sync.sv
`timescale 1ns/1ps
module prbs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= 1'b0;
        else         pipe_q[s] <= (s == 0) ? d_i : pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/prbs_miss_policy.sv
`timescale 1ns/1ps
module prbs_miss_policy
  import prbs_lockstep_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SKIP  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             exp_bit_i,
  input  logic             rx_bit_i,
  input  logic [CNT_W-1:0] threshold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fault_o
);

  localparam int unsigned SK_W = (SKIP < 2) ? 1 : $clog2(SKIP + 1);
  localparam chk_state_e  ST_INIT = (SKIP == 0) ? CHK_ACTIVE : CHK_WARMUP;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  chk_state_e       state_q;
  logic [SK_W-1:0]  skip_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             miss, trip;

  always_comb begin
    miss    = exp_bit_i ^ rx_bit_i;
    cnt_nxt = cnt_q;
    if (miss && cnt_q != CNT_MAX) cnt_nxt = cnt_q + CNT_W'(1);
    else if (!miss && cnt_q != '0) cnt_nxt = cnt_q - CNT_W'(1);
    trip = (threshold_i != '0) && (cnt_nxt >= threshold_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      skip_q  <= '0;
      cnt_q   <= '0;
    end else if (step_i) begin
      unique case (state_q)
        CHK_WARMUP: begin
          skip_q <= skip_q + SK_W'(1);
          if (skip_q == SK_W'(SKIP - 1)) state_q <= CHK_ACTIVE;
        end
        CHK_ACTIVE: begin
          cnt_q <= cnt_nxt;
          if (trip) state_q <= CHK_FAULT;
        end
        default: state_q <= CHK_FAULT;
      endcase
    end
  end

  assign cnt_o   = cnt_q;
  assign fault_o = (state_q == CHK_FAULT);

endmodule

// File: rtl/prbs_lockstep_chk.sv
`timescale 1ns/1ps
module prbs_lockstep_chk
  import prbs_lockstep_pkg::*;
#(
  parameter int unsigned          DIV_W  = 4,
  parameter int unsigned          CNT_W  = 8,
  parameter int unsigned          SYNC_N = 2,
  parameter int unsigned          SKIP   = 2,
  parameter logic [PRED_W-1:0]    SEED   = PRED_SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_log2_i,
  input  logic [CNT_W-1:0] threshold_i,
  input  logic             prbs_bit_i,
  output logic             comp_clk_o,
  output logic             enable_o,
  output logic             fault_o
);

  logic              step;
  logic              rx_bit;
  logic [PRED_W-1:0] pred_state;
  logic [CNT_W-1:0]  miss_cnt;
  logic              fault;

  prbs_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .div_log2_i (div_log2_i),
    .step_o     (step),
    .clk_o      (comp_clk_o)
  );

  prbs_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (prbs_bit_i),
    .q_o    (rx_bit)
  );

  prbs_pred_lfsr #(.W(PRED_W), .TAPS(PRED_TAPS), .SEED(SEED)) u_pred (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .state_o (pred_state)
  );

  prbs_miss_policy #(.CNT_W(CNT_W), .SKIP(SKIP)) u_policy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .exp_bit_i   (pred_state[PRED_W-1]),
    .rx_bit_i    (rx_bit),
    .threshold_i (threshold_i),
    .cnt_o       (miss_cnt),
    .fault_o     (fault)
  );

  assign fault_o  = fault;
  assign enable_o = ~fault;

endmodule

// File: rtl/prbs_lockstep_chk_sva.sv
`timescale 1ns/1ps
module prbs_lockstep_chk_sva #(
  parameter int unsigned W     = 36,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [CNT_W-1:0] threshold_i,
  input logic             comp_clk_o,
  input logic             fault_o,
  input logic [W-1:0]     pred_state,
  input logic [CNT_W-1:0] miss_cnt
);

  assert_fault_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  assert_fault_on_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $rose(comp_clk_o));

  assert_cnt_unit_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt == $past(miss_cnt)) ||
    (miss_cnt == $past(miss_cnt) + CNT_W'(1)) ||
    (miss_cnt == $past(miss_cnt) - CNT_W'(1)));

  assert_clk_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(comp_clk_o));

  assert_cnt_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(miss_cnt) && $stable(pred_state));

  assert_pred_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_state != '0);

  assert_thr_zero_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (threshold_i == '0) && !fault_o |=> !fault_o);

endmodule

bind prbs_lockstep_chk prbs_lockstep_chk_sva #(.W(prbs_lockstep_pkg::PRED_W), .CNT_W(CNT_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .threshold_i (threshold_i),
  .comp_clk_o  (comp_clk_o),
  .fault_o     (fault_o),
  .pred_state  (pred_state),
  .miss_cnt    (miss_cnt)
);

// File: tb/prbs_lockstep_chk_tb.sv
`timescale 1ns/1ps
module prbs_lockstep_chk_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b1;
  logic [3:0] div_log2 = 4'd2;
  logic [7:0] thr = 8'd1;
  logic       corrupt = 1'b0;
  logic       prbs_bit;
  logic       comp_clk, enable, fault;
  logic [35:0] comp_q;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  // independent companion model, per R4
  always @(posedge comp_clk or negedge rst_n) begin
    if (!rst_n) comp_q <= 36'hA5C31E9F7;
    else        comp_q <= {comp_q[34:0], comp_q[35] ^ comp_q[24]};
  end
  assign prbs_bit = comp_q[35] ^ corrupt;

  prbs_lockstep_chk u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .run_i       (run),
    .div_log2_i  (div_log2),
    .threshold_i (thr),
    .prbs_bit_i  (prbs_bit),
    .comp_clk_o  (comp_clk),
    .enable_o    (enable),
    .fault_o     (fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] n, input logic [7:0] t);
    @(negedge clk);
    rst_n = 1'b0; run = 1'b1; corrupt = 1'b0; div_log2 = n; thr = t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one corrupt flag per companion step, starting after the next rising edge
  task automatic step_bits(input int n, input logic [63:0] pat);
    for (int i = 0; i < n; i++) begin
      @(posedge comp_clk);
      #1 corrupt = (i < 64) ? pat[i] : 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 enable in reset", enable, 1);
    chk("R1 fault in reset", fault, 0);
    chk("R1 comp_clk in reset", comp_clk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enable after release", enable, 1);
  endtask

  task automatic t_divider(input logic [3:0] n, input int period);
    int c;
    int hi;
    int per;
    @(negedge clk);
    rst_n = 1'b0; div_log2 = n; thr = 8'd1; corrupt = 1'b0; run = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    c = 0;
    while (!comp_clk) begin @(posedge clk); #1; c++; end
    chk("R2 first rising edge", c, period / 2);
    hi = 0;
    while (comp_clk) begin @(posedge clk); #1; hi++; end
    per = hi;
    while (!comp_clk) begin @(posedge clk); #1; per++; end
    chk("R2 high time", hi, period / 2);
    chk("R2 period", per, period);
  endtask

  task automatic t_clean(input logic [3:0] n, input int steps);
    do_reset(n, 8'd1);
    step_bits(steps, 64'd0);
    @(negedge clk);
    chk("R4 clean stream keeps enable", enable, 1);
  endtask

  task automatic t_skip();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b1; div_log2 = 4'd2; thr = 8'd1;
    corrupt = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge comp_clk);
    #1 corrupt = 1'b0;
    step_bits(20, 64'd0);
    @(negedge clk);
    chk("R5 first two compares skipped", enable, 1);
    step_bits(1, 64'd1);
    @(negedge clk);
    chk("R6 no fault before compare", fault, 0);
    @(posedge comp_clk);
    #1;
    chk("R6 fault with clock edge", fault, 1);
    chk("R6 enable dropped", enable, 0);
  endtask

  task automatic t_threshold();
    do_reset(4'd2, 8'd3);
    step_bits(3, 64'd0);
    step_bits(20, 64'h55555);
    step_bits(1, 64'd0);
    @(negedge clk);
    chk("R6 alternating bits stay below threshold", enable, 1);
    step_bits(3, 64'h7);
    @(negedge clk);
    chk("R6 score two below threshold", fault, 0);
    step_bits(1, 64'd0);
    @(negedge clk);
    chk("R6 third mismatch trips", fault, 1);
    step_bits(30, 64'd0);
    @(negedge clk);
    chk("R7 fault latched", fault, 1);
    chk("R7 enable stays low", enable, 0);
  endtask

  task automatic t_disable();
    do_reset(4'd2, 8'd0);
    step_bits(40, 64'hFF_FFFF_FFFF);
    step_bits(2, 64'd0);
    @(negedge clk);
    chk("R8 zero threshold no fault", fault, 0);
    chk("R8 zero threshold enable", enable, 1);
  endtask

  task automatic t_suspend();
    logic lvl;
    int changes;
    do_reset(4'd3, 8'd1);
    step_bits(5, 64'd0);
    repeat (3) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    lvl = comp_clk;
    corrupt = 1'b1;
    changes = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (comp_clk != lvl) changes++;
    end
    chk("R3 clock frozen while stopped", changes, 0);
    chk("R3 no fault while stopped", fault, 0);
    corrupt = 1'b0;
    repeat (4) @(negedge clk);
    run = 1'b1;
    step_bits(20, 64'd0);
    @(negedge clk);
    chk("R3 lockstep after resume", enable, 1);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_divider(4'd2, 4);
    t_divider(4'd3, 8);
    t_divider(4'd0, 4);
    t_divider(4'd5, 32);
    t_clean(4'd2, 300);
    t_clean(4'd3, 120);
    t_skip();
    t_threshold();
    t_disable();
    t_suspend();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule